// File: doc/BRIEF.md
# Indirect-Addressed Serial Management Slave

This block is the receiving end of a two-wire serial management link inside a PHY. It runs entirely on the management clock `mdc`, which the master may stop or stretch at any time. Each rising edge samples one bit of `mdio_in`. The block looks for a synchronising run of ones, then decodes a header that carries a start pattern, an operation, a port number and a device number. After the header come a two-bit turnaround and a 16-bit address or data word. The line is open-drain. The block never drives a one: it asserts `mdio_oe` to pull the line low and releases it otherwise.

Registers are reached indirectly. An address frame loads a 16-bit pointer that is kept separately for each of the three supported devices (1, 3 and 4). Later write, read and read-with-increment frames for that device use this pointer. A read-with-increment frame advances the pointer by one once its data has been shifted out. The register contents themselves are outside this block. It presents device, pointer, write data and one-cycle read and write strobes to a register file, and it samples that file's read data at the end of the turnaround.

Top module: `mdiom_slave`

## Requirements
- R1: The block accepts a start pattern only after it has sampled at least 32 consecutive ones while idle. A zero sampled before the run reaches 32 clears the run, and the frame that follows is ignored.
- R2: A frame starts with the bits 0,0. If the second start bit is 1, the frame is dropped with no strobe and no drive.
- R3: A frame is acted on only when its 5-bit port field equals `prt_strap` and its 5-bit device field is 1, 3 or 4. Any other frame leaves every stored pointer and the register file untouched.
- R4: Opcode 00 (address frame) stores its 16-bit field, received MSB first, as the pointer of the addressed device.
- R5: Opcode 01 (write frame) raises `rf_wr` for exactly one `mdc` cycle, starting at the rising edge that samples data bit 0. In that cycle `rf_dev`, `rf_addr` (the device's pointer) and `rf_wdata` are valid. If the turnaround bits are not 1 then 0, the frame is dropped.
- R6: On opcode 11 (read) and opcode 10 (read with increment), the block leaves the first turnaround bit released. It drives 0 during the second turnaround bit, and `rf_rd` is high for that same single cycle with `rf_dev` and `rf_addr` valid.
- R7: Read data is sent MSB first. Each bit appears after the rising edge that samples the bit before it, so the master samples data bit 15 on the edge after the turnaround. A 0 is sent as `mdio_oe`=1 and a 1 as `mdio_oe`=0.
- R8: After a read-with-increment frame completes, the device's pointer is one higher, and it wraps from 0xFFFF to 0x0000. A plain read leaves the pointer unchanged.
- R9: Each device's pointer is independent and persists across frames until that device receives a new address frame or an increment.
- R10: After reset, and whenever no frame is being answered, `mdio_oe`, `rf_rd` and `rf_wr` are low and all pointers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_oe | output | 1 | High pulls the data line low; low releases it |
| prt_strap | input | 5 | Port number this slave answers to |
| rf_dev | output | 5 | Device number of the current access |
| rf_addr | output | 16 | Stored pointer of the current device |
| rf_wdata | output | 16 | Write data, valid while `rf_wr` is high |
| rf_wr | output | 1 | One-cycle register write strobe |
| rf_rd | output | 1 | One-cycle register read strobe |
| rf_rdata | input | 16 | Register read data, sampled at the end of the `rf_rd` cycle |

## Verification
The hardest state to reach is one where the synchronisation run is cut short but the frame after it still looks valid. The preamble count carries over from whatever ones the line held before, including trailing idle ones and the tail bits of a frame the block has already dropped. To reach it, the stimulus first sends a frame addressed to another port whose data ends in zeros, or places a stray zero inside a run of ones. It then follows immediately with a 31-one preamble and a well-formed frame, so that only the count rule stops the frame. A later read shows that the frame had no effect. The pointer wrap is reached by loading 0xFFFF and then issuing a read with increment.

// File: rtl/mdiom_pkg.sv
package mdiom_pkg;

    localparam int PRE_RUN   = 32;
    localparam int WORD_W    = 16;
    localparam int ID_W      = 5;
    localparam int HDR_W     = 2 + 2 + ID_W + ID_W;
    localparam int NDEV      = 3;
    localparam int SLOT_W    = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam int CNT_W     = $clog2(WORD_W);

    // header field positions after all HDR_W bits are shifted in
    localparam int OP_HI     = HDR_W - 3;
    localparam int PRT_HI    = OP_HI - 2;
    localparam int DEV_HI    = PRT_HI - ID_W;

    localparam logic [ID_W-1:0] DEV_LIST [NDEV] = '{5'd1, 5'd3, 5'd4};

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_HDR,
        PH_TA1,
        PH_TA2,
        PH_DATA
    } phase_e;

    localparam logic [1:0] OPC_ADDR  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_RDINC = 2'b10;

    function automatic logic dev_known(input logic [ID_W-1:0] d);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (d == DEV_LIST[i]) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic [SLOT_W-1:0] dev_slot(input logic [ID_W-1:0] d);
        logic [SLOT_W-1:0] s;
        s = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (d == DEV_LIST[i]) s = SLOT_W'(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/mdiom_preamble.sv
module mdiom_preamble #(
    parameter int RUN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hunt_i,
    input  logic bit_i,
    output logic seen_o
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!hunt_i || !bit_i) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(RUN)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign seen_o = (cnt_q == CW'(RUN));

    // R1: the run counter saturates and never passes the required length
    a_r1_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(RUN));

    // R1: a zero sampled while hunting leaves no credit for the next frame
    a_r1_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_i && !bit_i) |=> !seen_o);

endmodule

// File: rtl/mdiom_addr_bank.sv
module mdiom_addr_bank #(
    parameter int NSLOT = 3,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] sel_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_i,
    output logic [AW-1:0] cur_o
);
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [AW-1:0] slot_d [NSLOT];
    logic [AW-1:0] slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (sel_i == SW'(g)) begin
                if (load_i)     slot_d[g] = load_val_i;
                else if (inc_i) slot_d[g] = slot_q[g] + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end
    end

    always_comb begin
        cur_o = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (sel_i == SW'(i)) cur_o = slot_q[i];
        end
    end

    // R8: an increment advances the selected pointer by exactly one, with wrap
    a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i) |=> (cur_o == AW'($past(cur_o) + 1'b1)) || (sel_i != $past(sel_i)));

    // R9: with no load or increment the selected pointer holds its value
    a_r9_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !load_i) |=> (cur_o == $past(cur_o)) || (sel_i != $past(sel_i)));

endmodule

// File: rtl/mdiom_slave.sv
module mdiom_slave
    import mdiom_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_in,
    output logic              mdio_oe,
    input  logic [ID_W-1:0]   prt_strap,
    output logic [ID_W-1:0]   rf_dev,
    output logic [WORD_W-1:0] rf_addr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              rf_wr,
    output logic              rf_rd,
    input  logic [WORD_W-1:0] rf_rdata
);

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [HDR_W-1:0]    hdr;
        logic [1:0]          op;
        logic [ID_W-1:0]     dev;
        logic [WORD_W-1:0]   data;
        logic                oe;
        logic                rd;
        logic                wr;
    } fr_t;

    fr_t fr_d, fr_q;

    logic              pre_seen;
    logic              bank_load;
    logic              bank_inc;
    logic [WORD_W-1:0] bank_cur;
    logic [HDR_W-1:0]  hdr_full;
    logic [WORD_W-1:0] data_in;
    logic              is_read;

    mdiom_preamble #(.RUN(PRE_RUN)) u_pre (
        .clk    (mdc),
        .rst_n  (rst_n),
        .hunt_i (fr_q.ph == PH_HUNT),
        .bit_i  (mdio_in),
        .seen_o (pre_seen)
    );

    mdiom_addr_bank #(.NSLOT(NDEV), .AW(WORD_W)) u_bank (
        .clk        (mdc),
        .rst_n      (rst_n),
        .sel_i      (dev_slot(fr_q.dev)),
        .load_i     (bank_load),
        .load_val_i (data_in),
        .inc_i      (bank_inc),
        .cur_o      (bank_cur)
    );

    assign hdr_full = {fr_q.hdr[HDR_W-2:0], mdio_in};
    assign data_in  = {fr_q.data[WORD_W-2:0], mdio_in};
    assign is_read  = fr_q.op[1];

    always_comb begin
        fr_d      = fr_q;
        fr_d.rd   = 1'b0;
        fr_d.wr   = 1'b0;
        bank_load = 1'b0;
        bank_inc  = 1'b0;

        unique case (fr_q.ph)
            PH_HUNT: begin
                fr_d.oe = 1'b0;
                if (!mdio_in && pre_seen) begin
                    fr_d.ph  = PH_HDR;
                    fr_d.hdr = hdr_full;
                    fr_d.cnt = CNT_W'(1);
                end
            end
            PH_HDR: begin
                fr_d.hdr = hdr_full;
                fr_d.cnt = fr_q.cnt + 1'b1;
                if (fr_q.cnt == CNT_W'(1) && mdio_in) begin
                    fr_d.ph = PH_HUNT;
                end else if (fr_q.cnt == CNT_W'(HDR_W - 1)) begin
                    if (hdr_full[PRT_HI -: ID_W] == prt_strap &&
                        dev_known(hdr_full[DEV_HI -: ID_W])) begin
                        fr_d.ph  = PH_TA1;
                        fr_d.op  = hdr_full[OP_HI -: 2];
                        fr_d.dev = hdr_full[DEV_HI -: ID_W];
                    end else begin
                        fr_d.ph = PH_HUNT;
                    end
                end
            end
            PH_TA1: begin
                if (is_read) begin
                    fr_d.ph = PH_TA2;
                    fr_d.oe = 1'b1;
                    fr_d.rd = 1'b1;
                end else if (mdio_in) begin
                    fr_d.ph = PH_TA2;
                end else begin
                    fr_d.ph = PH_HUNT;
                end
            end
            PH_TA2: begin
                if (is_read) begin
                    fr_d.ph   = PH_DATA;
                    fr_d.cnt  = '0;
                    fr_d.data = rf_rdata;
                    fr_d.oe   = !rf_rdata[WORD_W-1];
                end else if (!mdio_in) begin
                    fr_d.ph  = PH_DATA;
                    fr_d.cnt = '0;
                end else begin
                    fr_d.ph = PH_HUNT;
                end
            end
            PH_DATA: begin
                fr_d.cnt = fr_q.cnt + 1'b1;
                if (is_read) begin
                    fr_d.data = {fr_q.data[WORD_W-2:0], 1'b0};
                    fr_d.oe   = !fr_q.data[WORD_W-2];
                end else begin
                    fr_d.data = data_in;
                end
                if (fr_q.cnt == CNT_W'(WORD_W - 1)) begin
                    fr_d.ph = PH_HUNT;
                    fr_d.oe = 1'b0;
                    if (fr_q.op == OPC_ADDR)  bank_load = 1'b1;
                    if (fr_q.op == OPC_WRITE) fr_d.wr   = 1'b1;
                    if (fr_q.op == OPC_RDINC) bank_inc  = 1'b1;
                end
            end
            default: fr_d.ph = PH_HUNT;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            fr_q     <= '0;
            fr_q.ph  <= PH_HUNT;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign mdio_oe  = fr_q.oe;
    assign rf_rd    = fr_q.rd;
    assign rf_wr    = fr_q.wr;
    assign rf_dev   = fr_q.dev;
    assign rf_wdata = fr_q.data;
    assign rf_addr  = bank_cur;

    // R10: the line is released whenever the parser is hunting
    a_r10_release_idle: assert property (@(posedge mdc) disable iff (!rst_n)
        (fr_q.ph == PH_HUNT) |-> !mdio_oe);

    // R6: the read strobe coincides with the slave pulling turnaround low
    a_r6_ta_low_with_read: assert property (@(posedge mdc) disable iff (!rst_n)
        rf_rd |-> mdio_oe);

    // R5: a write strobe lasts one cycle and never overlaps a read strobe
    a_r5_write_single: assert property (@(posedge mdc) disable iff (!rst_n)
        rf_wr |=> !rf_wr);
    a_r5_no_overlap: assert property (@(posedge mdc) disable iff (!rst_n)
        !(rf_wr && rf_rd));

    // R3: strobes only ever name a supported device
    a_r3_known_device: assert property (@(posedge mdc) disable iff (!rst_n)
        (rf_wr || rf_rd) |-> dev_known(rf_dev));

    // R7: after the read strobe the line is driven only while data is shifting
    a_r7_drive_after_rd: assert property (@(posedge mdc) disable iff (!rst_n)
        rf_rd |=> (fr_q.ph == PH_DATA));

endmodule

// File: tb/mdiom_slave_tb.sv
`timescale 1ns/1ps
module mdiom_slave_tb_top;

    localparam int CLK_PERIOD = 400;
    localparam logic [4:0] STRAP = 5'h13;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_drv = 1'b1;
    logic        mdio_in;
    logic        mdio_oe;
    logic [4:0]  rf_dev;
    logic [15:0] rf_addr, rf_wdata, rf_rdata;
    logic        rf_wr, rf_rd;

    always #(CLK_PERIOD/2) mdc = ~mdc;

    assign mdio_in = mdio_drv & ~mdio_oe;

    mdiom_slave dut_i (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .mdio_in   (mdio_in),
        .mdio_oe   (mdio_oe),
        .prt_strap (STRAP),
        .rf_dev    (rf_dev),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .rf_wr     (rf_wr),
        .rf_rd     (rf_rd),
        .rf_rdata  (rf_rdata)
    );

    // ---------------- register file environment ----------------
    logic [15:0] env_mem [int];

    function automatic logic [15:0] dflt(input logic [4:0] d, input logic [15:0] a);
        return 16'(a * 16'd3) ^ {d, 11'h2B1};
    endfunction

    function automatic int mkey(input logic [4:0] d, input logic [15:0] a);
        return (int'(d) << 16) | int'(a);
    endfunction

    initial rf_rdata = 16'h0;
    always @(negedge mdc) begin
        if (rf_wr) env_mem[mkey(rf_dev, rf_addr)] = rf_wdata;
        rf_rdata = env_mem.exists(mkey(rf_dev, rf_addr)) ?
                   env_mem[mkey(rf_dev, rf_addr)] : dflt(rf_dev, rf_addr);
    end

    // ---------------- reference model and timeline ----------------
    bit          mq[$];
    bit          eoe[$];
    string       stag[$];
    string       otag[int];
    logic [4:0]  rd_dev_e[int];
    logic [15:0] rd_addr_e[int];
    logic [4:0]  wr_dev_e[int];
    logic [15:0] wr_addr_e[int];
    logic [15:0] wr_data_e[int];
    logic [15:0] maddr[int];
    logic [15:0] mmem[int];
    int          hunt_ones = 0;
    string       cur_tag = "R10";

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_bit(input bit b);
        mq.push_back(b);
        eoe.push_back(1'b0);
        stag.push_back(cur_tag);
    endtask

    task automatic push_field(input int unsigned v, input int w);
        for (int k = w - 1; k >= 0; k--) push_bit(v[k]);
    endtask

    function automatic int tail_ones();
        int n = 0;
        for (int k = mq.size() - 1; k >= 0; k--) begin
            if (!mq[k]) break;
            n++;
        end
        return n;
    endfunction

    function automatic bit dev_ok(input logic [4:0] d);
        return (d == 5'd1) || (d == 5'd3) || (d == 5'd4);
    endfunction

    task automatic raw_bits(input int n, input bit b);
        for (int k = 0; k < n; k++) push_bit(b);
        hunt_ones = tail_ones();
    endtask

    task automatic add_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] prt, input logic [4:0] dev,
                             input logic [1:0] ta, input logic [15:0] data, input int idle);
        bit accept;
        bit rd_op;
        int base;
        logic [15:0] a;
        logic [15:0] v;
        rd_op  = op[1];
        accept = (hunt_ones + pre >= 32) && (st == 2'b00) && (prt == STRAP) &&
                 dev_ok(dev) && (rd_op || ta == 2'b10);
        for (int k = 0; k < pre; k++) push_bit(1'b1);
        base = mq.size();
        push_field(st, 2);
        push_field(op, 2);
        push_field(prt, 5);
        push_field(dev, 5);
        if (rd_op) begin
            push_field(2'b11, 2);
            push_field(16'hFFFF, 16);
        end else begin
            push_field(ta, 2);
            push_field(data, 16);
        end
        if (accept) begin
            a = maddr.exists(dev) ? maddr[dev] : 16'h0000;
            if (rd_op) begin
                v = mmem.exists(mkey(dev, a)) ? mmem[mkey(dev, a)] : dflt(dev, a);
                rd_dev_e[base + 15]  = dev;
                rd_addr_e[base + 15] = a;
                eoe[base + 15] = 1'b1;
                otag[base + 15] = "R6";
                for (int k = 0; k < 16; k++) begin
                    eoe[base + 16 + k]  = ~v[15 - k];
                    otag[base + 16 + k] = "R7";
                end
                if (op == 2'b10) maddr[dev] = 16'(a + 16'd1);
            end else if (op == 2'b00) begin
                maddr[dev] = data;
            end else begin
                wr_dev_e[base + 32]  = dev;
                wr_addr_e[base + 32] = a;
                wr_data_e[base + 32] = data;
                mmem[mkey(dev, a)] = data;
            end
        end
        for (int k = 0; k < idle; k++) push_bit(1'b1);
        if (accept) hunt_ones = idle;
        else        hunt_ones = tail_ones();
    endtask

    task automatic play();
        int total;
        total = mq.size() + 4;
        for (int i = 0; i < total; i++) begin
            bit    e_oe;
            string t;
            @(negedge mdc);
            t    = (i < stag.size()) ? stag[i] : "R10";
            e_oe = (i < eoe.size()) ? eoe[i] : 1'b0;
            chk(mdio_oe == e_oe, otag.exists(i) ? otag[i] : t, "mdio_oe", mdio_oe, e_oe);
            if (rd_dev_e.exists(i)) begin
                chk(rf_rd == 1'b1, "R6", "rf_rd", rf_rd, 1);
                chk(rf_dev == rd_dev_e[i], t, "rd dev", rf_dev, rd_dev_e[i]);
                chk(rf_addr == rd_addr_e[i], t, "rd addr", rf_addr, rd_addr_e[i]);
            end else begin
                chk(rf_rd == 1'b0, t, "rf_rd idle", rf_rd, 0);
            end
            if (wr_dev_e.exists(i)) begin
                chk(rf_wr == 1'b1, "R5", "rf_wr", rf_wr, 1);
                chk(rf_dev == wr_dev_e[i], "R5", "wr dev", rf_dev, wr_dev_e[i]);
                chk(rf_addr == wr_addr_e[i], t, "wr addr", rf_addr, wr_addr_e[i]);
                chk(rf_wdata == wr_data_e[i], "R5", "wr data", rf_wdata, wr_data_e[i]);
            end else begin
                chk(rf_wr == 1'b0, t, "rf_wr idle", rf_wr, 0);
            end
            mdio_drv = (i < mq.size()) ? mq[i] : 1'b1;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge mdc);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge mdc);
        // R10: reset state
        chk(mdio_oe == 1'b0, "R10", "reset mdio_oe", mdio_oe, 0);
        chk(rf_wr == 1'b0, "R10", "reset rf_wr", rf_wr, 0);
        chk(rf_rd == 1'b0, "R10", "reset rf_rd", rf_rd, 0);
        chk(rf_addr == 16'h0, "R10", "reset pointer", rf_addr, 0);
        rst_n = 1'b1;

        // R4/R5: address then write, device 1
        cur_tag = "R4";
        add_frame(32, 2'b00, 2'b00, STRAP, 5'd1, 2'b10, 16'h1234, 2);
        add_frame(32, 2'b00, 2'b01, STRAP, 5'd1, 2'b10, 16'hBEEF, 2);
        // R6/R7: read back written word
        cur_tag = "R7";
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd1, 2'b00, 16'h0, 2);
        // R8: read with increment, device 3
        cur_tag = "R8";
        add_frame(32, 2'b00, 2'b00, STRAP, 5'd3, 2'b10, 16'h00FF, 2);
        add_frame(32, 2'b00, 2'b10, STRAP, 5'd3, 2'b00, 16'h0, 2);
        add_frame(32, 2'b00, 2'b10, STRAP, 5'd3, 2'b00, 16'h0, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd3, 2'b00, 16'h0, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd3, 2'b00, 16'h0, 2);
        // R9: device 1 pointer unaffected by device 3 traffic
        cur_tag = "R9";
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd1, 2'b00, 16'h0, 2);
        // R3: wrong port and unsupported device leave pointers alone
        cur_tag = "R3";
        add_frame(32, 2'b00, 2'b00, 5'h07, 5'd1, 2'b10, 16'h5550, 2);
        add_frame(32, 2'b00, 2'b00, STRAP, 5'd2, 2'b10, 16'h5550, 2);
        add_frame(32, 2'b00, 2'b01, STRAP, 5'd0, 2'b10, 16'h7770, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd1, 2'b00, 16'h0, 2);
        // R8: wrap from 0xFFFF, device 4
        cur_tag = "R8";
        add_frame(32, 2'b00, 2'b00, STRAP, 5'd4, 2'b10, 16'hFFFF, 2);
        add_frame(32, 2'b00, 2'b10, STRAP, 5'd4, 2'b00, 16'h0, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd4, 2'b00, 16'h0, 2);
        // R5: bad turnaround drops the write
        cur_tag = "R5";
        add_frame(32, 2'b00, 2'b01, STRAP, 5'd1, 2'b11, 16'hA5A0, 2);
        add_frame(32, 2'b00, 2'b01, STRAP, 5'd1, 2'b00, 16'hA5A0, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd1, 2'b00, 16'h0, 2);
        // R2: bad start pattern
        cur_tag = "R2";
        add_frame(32, 2'b01, 2'b01, STRAP, 5'd1, 2'b10, 16'h1110, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd1, 2'b00, 16'h0, 2);
        // R1: short preamble after a dropped frame ending in zero
        cur_tag = "R1";
        add_frame(32, 2'b00, 2'b01, 5'h00, 5'd1, 2'b10, 16'h0000, 0);
        add_frame(31, 2'b00, 2'b01, STRAP, 5'd1, 2'b10, 16'h0F00, 0);
        // R1: zero inside the run
        raw_bits(20, 1'b1);
        raw_bits(1, 1'b0);
        add_frame(31, 2'b00, 2'b00, STRAP, 5'd1, 2'b10, 16'h4440, 2);
        // R1: long preamble accepted, pointer of device 1 still 0x1234
        add_frame(40, 2'b00, 2'b11, STRAP, 5'd1, 2'b00, 16'h0, 2);
        // R4/R5: write device 4 at a fresh address and read it back
        cur_tag = "R4";
        add_frame(32, 2'b00, 2'b00, STRAP, 5'd4, 2'b10, 16'h8001, 2);
        add_frame(32, 2'b00, 2'b01, STRAP, 5'd4, 2'b10, 16'h3C5A, 2);
        add_frame(32, 2'b00, 2'b11, STRAP, 5'd4, 2'b00, 16'h0, 3);

        play();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule